// File: doc/BRIEF.md
# DMA Channel Register Block

This block holds the programming state of a single DMA channel: a control/status word, a running transfer address, a byte count and an upper-address base word. A CPU reaches them through a simple word-wide bus with a write enable and a read strobe. Bus address bits [3:2] select the register, so the block answers in a 16-byte window.

Control writes are rewritten before they are stored. The block can issue a one-cycle reset pulse to the attached device. It can clear or force the drain bit, and it always forces a fixed version code into the top nibble.

The attached device engine does two things to the block. Its interrupt request line sets and clears the pending flag and drives the interrupt output. Its completion strobe reports a byte length, which advances the transfer address and marks the channel pending. The memory-side bus master, address translation and data FIFOs sit outside this block.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the control/status word (index 0) reads 0xA0000000. The address (index 1), count (index 2) and base (index 3) words read 0. `irq_o` and `dev_rst_o` are low.
- R2: Bus address bits [3:2] pick the register index. Bits [1:0] and every bit above bit 3 are ignored.
- R3: A control write stores `{4'hA, wdata[27:0]}` after one rewrite, picked in this priority. If bit 7 is set, nothing else changes. Otherwise, if bit 6 is set, bit 6 is stored as 0. Otherwise, if the whole write is zero, bit 6 is stored as 1, giving 0xA0000040.
- R4: A control write with bit 7 set drives `dev_rst_o` high for exactly one cycle, the cycle after the write edge. No other write drives it.
- R5: A control write with bit 4 (interrupt enable) clear deasserts `irq_o`. A control write with bit 4 set leaves `irq_o` unchanged.
- R6: A write to index 1 stores the data in the address word and sets bit 26 (loaded) of the control word.
- R7: A rising `dev_irq_i` sets control bit 0 and asserts `irq_o` on the next edge. A falling `dev_irq_i` clears both.
- R8: A `done_i` strobe adds `done_len_i` to the address word and sets control bit 0, with `irq_o` unchanged.
- R9: When `done_i` and a write to index 1 fall in the same cycle, the address word takes the written value. Control bit 0 is still set.
- R10: `rdata_o` shows the selected word combinationally while `rd_en_i` is high and is 0 otherwise. Reads change no state.
- R11: The count and base words store and return the full 32-bit written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write enable |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | ADDR_W (8) | Bus byte address |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data |
| dev_irq_i | input | 1 | Device interrupt request level |
| done_i | input | 1 | Device transfer completion strobe |
| done_len_i | input | LEN_W (16) | Bytes moved by the completed transfer |
| irq_o | output | 1 | Interrupt output |
| dev_rst_o | output | 1 | One-cycle device reset pulse |

## Verification
The hardest situation to reach is a collision in one cycle: a CPU write to the address word on the same edge as a completion strobe. The stimulus lines these up by driving the write and the strobe in the same task, between the same two edges. It first clears the pending flag through a control write, so that the flag being set again can be seen. Interrupt masking is reached by holding the device request high, then issuing control writes with the enable bit set and then clear. The falling edge of the request is checked afterwards on an already-lowered output.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned NREG  = 4;
  localparam int unsigned IDX_W = $clog2(NREG);

  localparam int unsigned B_PEND   = 0;
  localparam int unsigned B_IEN    = 4;
  localparam int unsigned B_DRAIN  = 6;
  localparam int unsigned B_DRST   = 7;
  localparam int unsigned B_DIR    = 8;
  localparam int unsigned B_LOADED = 26;

  localparam logic [3:0]    VER_NIB  = 4'hA;
  localparam logic [DW-1:0] CTRL_RST = {VER_NIB, {(DW-4){1'b0}}};

  typedef enum logic [IDX_W-1:0] {
    REG_CTRL = 2'd0,
    REG_ADDR = 2'd1,
    REG_CNT  = 2'd2,
    REG_BASE = 2'd3
  } reg_idx_e;

  // reset > drain clear > zero-forces-drain, then version nibble
  function automatic logic [DW-1:0] ctrl_rewrite(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    r = v;
    if (v[B_DRST])       r = v;
    else if (v[B_DRAIN]) r[B_DRAIN] = 1'b0;
    else if (v == '0)    r[B_DRAIN] = 1'b1;
    return {VER_NIB, r[DW-5:0]};
  endfunction
endpackage

// File: rtl/dma_irq_gen.sv
module dma_irq_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dev_irq_i,
  input  logic ctrl_wr_i,
  input  logic ien_i,
  output logic rise_o,
  output logic fall_o,
  output logic irq_o
);
  logic req_q;
  logic irq_q;

  assign rise_o = dev_irq_i & ~req_q;
  assign fall_o = ~dev_irq_i & req_q;
  assign irq_o  = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      req_q <= dev_irq_i;
      if (rise_o)                 irq_q <= 1'b1;
      else if (fall_o)            irq_q <= 1'b0;
      else if (ctrl_wr_i && !ien_i) irq_q <= 1'b0;
    end
  end

  a_r7_rise_sets_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> irq_o);
  a_r7_fall_clears_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !irq_o);
  a_r5_mask_write_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && !ien_i && !rise_o) |=> !irq_o);
endmodule

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
  import dma_regs_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          loaded_i,
  input  logic          pend_set_i,
  input  logic          pend_clr_i,
  output logic [DW-1:0] ctrl_o,
  output logic          dev_rst_o
);
  logic [DW-1:0] ctrl_q, ctrl_d;
  logic          drst_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_i)     ctrl_d = ctrl_rewrite(wdata_i);
    if (loaded_i) ctrl_d[B_LOADED] = 1'b1;
    // device events override the written pending bit
    if (pend_set_i)      ctrl_d[B_PEND] = 1'b1;
    else if (pend_clr_i) ctrl_d[B_PEND] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      drst_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      drst_q <= wr_i & wdata_i[B_DRST];
    end
  end

  assign ctrl_o    = ctrl_q;
  assign dev_rst_o = drst_q;

  a_r4_pulse_after_reset_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[B_DRST]) |=> dev_rst_o);
  a_r4_no_pulse_otherwise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && wdata_i[B_DRST]) |=> !dev_rst_o);
  a_r6_loaded_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_i |=> ctrl_o[B_LOADED]);
  a_r8_pending_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_set_i |=> ctrl_o[B_PEND]);
endmodule

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt
  import dma_regs_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             adv_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [DW-1:0]    addr_o
);
  logic [DW-1:0] addr_q;
  logic [DW-1:0] len_ext;

  assign len_ext = DW'(len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (wr_i)  addr_q <= wdata_i;
    else if (adv_i) addr_q <= addr_q + len_ext;
  end

  assign addr_o = addr_q;

  a_r8_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_i) |=> addr_o == $past(addr_o) + $past(len_ext));
  a_r9_cpu_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> addr_o == $past(wdata_i));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              dev_irq_i,
  input  logic              done_i,
  input  logic [LEN_W-1:0]  done_len_i,
  output logic              irq_o,
  output logic              dev_rst_o
);
  localparam int unsigned IDX_LSB = 2;

  logic [IDX_W-1:0] idx;
  logic [NREG-1:0]  wsel;
  logic [DW-1:0]    regs_w [NREG];
  logic             irq_rise, irq_fall;

  assign idx = addr_i[IDX_LSB +: IDX_W];

  always_comb begin
    wsel = '0;
    wsel[idx] = wr_en_i;
  end

  dma_irq_gen u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dev_irq_i (dev_irq_i),
    .ctrl_wr_i (wsel[REG_CTRL]),
    .ien_i     (wdata_i[B_IEN]),
    .rise_o    (irq_rise),
    .fall_o    (irq_fall),
    .irq_o     (irq_o)
  );

  dma_ctrl_reg u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wsel[REG_CTRL]),
    .wdata_i    (wdata_i),
    .loaded_i   (wsel[REG_ADDR]),
    .pend_set_i (irq_rise | done_i),
    .pend_clr_i (irq_fall),
    .ctrl_o     (regs_w[REG_CTRL]),
    .dev_rst_o  (dev_rst_o)
  );

  dma_addr_cnt #(.LEN_W(LEN_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wsel[REG_ADDR]),
    .wdata_i (wdata_i),
    .adv_i   (done_i),
    .len_i   (done_len_i),
    .addr_o  (regs_w[REG_ADDR])
  );

  // plain storage words
  for (genvar g = 2; g < NREG; g++) begin : g_plain
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     word_q <= '0;
      else if (wsel[g]) word_q <= wdata_i;
    end
    assign regs_w[g] = word_q;
  end

  assign rdata_o = rd_en_i ? regs_w[idx] : '0;

  a_r10_read_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == '0);
  a_r11_plain_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx == REG_CNT) |=> regs_w[REG_CNT] == $past(wdata_i));
endmodule

// File: tb/dma_chan_regs_tb.sv
`timescale 1ns/1ps
module dma_chan_regs_tb;
  localparam int ADDR_W = 8;
  localparam int LEN_W  = 16;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic              dev_irq_i = 1'b0, done_i = 1'b0;
  logic [LEN_W-1:0]  done_len_i = '0;
  logic              irq_o, dev_rst_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  dma_chan_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .dev_irq_i(dev_irq_i), .done_i(done_i), .done_len_i(done_len_i),
    .irq_o(irq_o), .dev_rst_o(dev_rst_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compare read data against queued expectations
  always @(negedge clk) begin
    if (rd_en_i && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      chk(it.tag, rdata_o, it.exp);
    end
  end

  task automatic cpu_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic cpu_rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    rd_en_i = 1'b1; addr_i = a;
    sb_q.push_back('{exp, tag});
    @(posedge clk); #1;
    rd_en_i = 1'b0;
  endtask

  task automatic wr_with_done(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                              input logic [LEN_W-1:0] len);
    @(posedge clk); #1;
    wr_en_i = 1'b1; addr_i = a; wdata_i = d; done_i = 1'b1; done_len_i = len;
    @(posedge clk); #1;
    wr_en_i = 1'b0; done_i = 1'b0;
  endtask

  task automatic done_pulse(input logic [LEN_W-1:0] len);
    @(posedge clk); #1;
    done_i = 1'b1; done_len_i = len;
    @(posedge clk); #1;
    done_i = 1'b0;
  endtask

  task automatic set_irq(input logic v);
    @(posedge clk); #1;
    dev_irq_i = v;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R1 reset state
    chk("R1 irq_o", {31'b0, irq_o}, 32'h0);
    chk("R1 dev_rst_o", {31'b0, dev_rst_o}, 32'h0);
    cpu_rd(8'h00, 32'hA000_0000, "R1 ctrl");
    cpu_rd(8'h04, 32'h0, "R1 addr");
    cpu_rd(8'h08, 32'h0, "R1 count");
    cpu_rd(8'h0C, 32'h0, "R1 base");

    // R2, R11: decode ignores high and low bits
    cpu_wr(8'h08, 32'h1234_5678);
    cpu_rd(8'h1B, 32'h1234_5678, "R2 R11 count alias");
    cpu_wr(8'hFC, 32'hF00D_CAFE);
    cpu_rd(8'h0C, 32'hF00D_CAFE, "R2 R11 base alias");

    // R3: drain cleared, zero forces drain
    cpu_wr(8'h00, 32'h0000_0040);
    cpu_rd(8'h00, 32'hA000_0000, "R3 drain cleared");
    chk("R4 no pulse", {31'b0, dev_rst_o}, 32'h0);
    cpu_wr(8'h00, 32'h0);
    cpu_rd(8'h00, 32'hA000_0040, "R3 zero forces drain");

    // R3, R4: reset bit keeps drain, pulses once
    cpu_wr(8'h00, 32'hFFFF_FFFF);
    chk("R4 pulse high", {31'b0, dev_rst_o}, 32'h1);
    @(posedge clk); #1;
    chk("R4 pulse single", {31'b0, dev_rst_o}, 32'h0);
    cpu_rd(8'h00, 32'hAFFF_FFFF, "R3 reset bit stored");
    cpu_wr(8'h00, 32'h5000_0110);
    cpu_rd(8'h00, 32'hA000_0110, "R3 nibble forced");

    // R7 rise and fall
    set_irq(1'b1);
    chk("R7 irq rise", {31'b0, irq_o}, 32'h1);
    cpu_rd(8'h00, 32'hA000_0111, "R7 pend set");
    set_irq(1'b0);
    chk("R7 irq fall", {31'b0, irq_o}, 32'h0);
    cpu_rd(8'h00, 32'hA000_0110, "R7 pend clear");

    // R5 masking with request held high
    set_irq(1'b1);
    cpu_wr(8'h00, 32'h0000_0011);
    chk("R5 enable keeps irq", {31'b0, irq_o}, 32'h1);
    cpu_wr(8'h00, 32'h0000_0100);
    chk("R5 mask drops irq", {31'b0, irq_o}, 32'h0);
    cpu_rd(8'h00, 32'hA000_0100, "R5 ctrl after mask");
    set_irq(1'b0);
    chk("R5 irq stays low", {31'b0, irq_o}, 32'h0);

    // R6 loaded flag
    cpu_wr(8'h04, 32'h0000_1000);
    cpu_rd(8'h04, 32'h0000_1000, "R6 addr value");
    cpu_rd(8'h00, 32'hA400_0100, "R6 loaded bit");

    // R8 completion advances address
    done_pulse(16'h0020);
    chk("R8 irq unchanged", {31'b0, irq_o}, 32'h0);
    cpu_rd(8'h04, 32'h0000_1020, "R8 addr advanced");
    cpu_rd(8'h00, 32'hA400_0101, "R8 pend set");
    done_pulse(16'hFFFF);
    cpu_rd(8'h04, 32'h0001_101F, "R8 max len");

    // R9 collision
    cpu_wr(8'h00, 32'h0400_0100);
    cpu_rd(8'h00, 32'hA400_0100, "R9 pend cleared first");
    wr_with_done(8'h04, 32'h0000_2000, 16'h0010);
    cpu_rd(8'h04, 32'h0000_2000, "R9 cpu wins");
    cpu_rd(8'h00, 32'hA400_0101, "R9 pend still set");

    // R10 idle read and repeat reads
    @(negedge clk);
    chk("R10 idle rdata", rdata_o, 32'h0);
    cpu_rd(8'h04, 32'h0000_2000, "R10 repeat read");
    cpu_rd(8'h04, 32'h0000_2000, "R10 repeat read 2");

    repeat (2) @(posedge clk);
    if (sb_q.size() != 0) chk("R10 scoreboard drained", sb_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule